// File: doc/BRIEF.md
# Load/Store Ordering Queue

This block keeps a record of memory operations that have been dispatched but have not yet finished executing. Each operation is identified by a sequence tag. A larger tag means a younger operation. Operations that can read go into a load bank. Operations that can write go into a store bank. An operation that can both read and write goes into both banks. Each bank entry also remembers whether the operation has side effects, because such an entry acts as a fence.

The block has three ports of activity. Dispatch offers an operation on the allocate port and learns in the same cycle whether it was taken. The scheduler puts a tag on the query port and learns combinationally whether that operation may issue under the ordering rules. When an operation finishes executing, its tag is presented on the completion port and its entries are freed. Two flags tell dispatch when a bank has reached its configured limit. Address comparison and data forwarding are not part of this block.

Each bank slot is a small state machine with three states. SLOT_FREE moves to SLOT_HELD (take, plain) or SLOT_FENCE (take, side effect) when the slot is chosen by an accepted allocation. SLOT_HELD and SLOT_FENCE both return to SLOT_FREE (retire) when the completion tag matches the slot's tag.

Top module: `mem_order_queue`

## Requirements
- R1: An allocation with both may-load and may-store low is never taken: `alloc_accepted` is 0 and no bank changes.
- R2: An allocation is taken only when every bank it needs has room. A bank's room is its limit, or its slot count when the limit is 0. An operation that may both load and store takes one entry in each bank.
- R3: A taken operation with `alloc_side_effect` high is marked as a fence in each bank it enters. A side-effecting store does not hold back later loads through this mark.
- R4: A queued store is not ready while any older store is queued.
- R5: A queued store is not ready while any older load is queued.
- R6: A queued load that is not also a store is not ready while any older store is queued.
- R7: A queued load that is not also a store is not ready while an older load fence is queued. Older plain loads never delay it.
- R8: `lq_full` is 1 exactly when the load limit is nonzero and the load occupancy equals it. `sq_full` follows the same rule for the store bank. With the default store limit of 0, `sq_full` stays 0.
- R9: A completion frees every entry holding its tag in both banks, fence marks included. A tag that is in neither bank reads as not ready, and a tag that is present and unblocked reads as ready.
- R10: An operation that sits in both banks is judged by the store rules (R4, R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation offered this cycle |
| alloc_tag | input | TAG_W | Sequence tag of the offered operation |
| alloc_may_load | input | 1 | Operation may read memory |
| alloc_may_store | input | 1 | Operation may write memory |
| alloc_side_effect | input | 1 | Operation has side effects (fence) |
| alloc_accepted | output | 1 | Offered operation is taken at the next edge |
| query_tag | input | TAG_W | Tag whose readiness is asked |
| query_ready | output | 1 | Queried operation may issue |
| done_valid | input | 1 | Completion this cycle |
| done_tag | input | TAG_W | Tag of the completed operation |
| lq_full | output | 1 | Load bank at its nonzero limit |
| sq_full | output | 1 | Store bank at its nonzero limit |

## Verification
`alloc_accepted` and `query_ready` are combinational, so the bench checks them 1 ns after it drives the inputs, in the same cycle and before the next rising edge. Allocations and completions change state at the next rising edge. The bench therefore checks the full flags and any readiness that depends on an allocation or completion only after that edge, once it has dropped the valid strobe. A sweep runs every 3-operation mix of the eight flag patterns, retiring them oldest-first and youngest-first. After each step it compares the readiness of every tag with an age-rule model.

// File: rtl/mo_pkg.sv
package mo_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_HELD  = 2'd1,
        SLOT_FENCE = 2'd2
    } slot_state_e;
endpackage

// File: rtl/mo_bank.sv
module mo_bank
    import mo_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int SLOTS = 4,
    parameter int LIMIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             put,
    input  logic [TAG_W-1:0] put_tag,
    input  logic             put_fence,
    input  logic             drop,
    input  logic [TAG_W-1:0] drop_tag,
    input  logic [TAG_W-1:0] ask_tag,
    output logic             room,
    output logic             full,
    output logic             ask_hit,
    output logic             ask_older,
    output logic             ask_older_fence
);
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam int CAP   = (LIMIT == 0) ? SLOTS : LIMIT;
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

    slot_state_e      state_q [SLOTS];
    slot_state_e      state_d [SLOTS];
    logic [TAG_W-1:0] tag_q   [SLOTS];
    logic [SLOTS-1:0] pick;
    logic [CNT_W-1:0] count;

    // choose the lowest free slot
    always_comb begin
        logic found;
        found = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            pick[i] = 1'b0;
            if (!found && state_q[i] == SLOT_FREE) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    // next state per slot
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            state_d[i] = state_q[i];
            unique case (state_q[i])
                SLOT_FREE: begin
                    if (put && pick[i])
                        state_d[i] = put_fence ? SLOT_FENCE : SLOT_HELD;
                end
                SLOT_HELD, SLOT_FENCE: begin
                    if (drop && tag_q[i] == drop_tag)
                        state_d[i] = SLOT_FREE;
                end
                default: state_d[i] = SLOT_FREE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (!rst_n) begin
                state_q[i] <= SLOT_FREE;
                tag_q[i]   <= '0;
            end else begin
                state_q[i] <= state_d[i];
                if (put && pick[i] && state_q[i] == SLOT_FREE)
                    tag_q[i] <= put_tag;
            end
        end
    end

    // outputs
    always_comb begin
        count           = '0;
        ask_hit         = 1'b0;
        ask_older       = 1'b0;
        ask_older_fence = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (state_q[i] != SLOT_FREE) begin
                count = count + CNT_W'(1);
                if (tag_q[i] == ask_tag)
                    ask_hit = 1'b1;
                if (tag_q[i] < ask_tag) begin
                    ask_older = 1'b1;
                    if (state_q[i] == SLOT_FENCE)
                        ask_older_fence = 1'b1;
                end
            end
        end
        room = (count < CAP_V);
        full = (LIMIT != 0) && (count == CAP_V);
    end
endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue #(
    parameter int TAG_W    = 6,
    parameter int LQ_SLOTS = 4,
    parameter int SQ_SLOTS = 4,
    parameter int LQ_LIMIT = 3,
    parameter int SQ_LIMIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             alloc_may_load,
    input  logic             alloc_may_store,
    input  logic             alloc_side_effect,
    output logic             alloc_accepted,
    input  logic [TAG_W-1:0] query_tag,
    output logic             query_ready,
    input  logic             done_valid,
    input  logic [TAG_W-1:0] done_tag,
    output logic             lq_full,
    output logic             sq_full
);
    logic lq_room, sq_room;
    logic lq_hit, lq_older, lq_older_fence;
    logic sq_hit, sq_older, sq_older_fence;

    assign alloc_accepted = alloc_valid
                          && (alloc_may_load || alloc_may_store)
                          && (!alloc_may_load  || lq_room)
                          && (!alloc_may_store || sq_room);

    mo_bank #(.TAG_W(TAG_W), .SLOTS(LQ_SLOTS), .LIMIT(LQ_LIMIT)) u_lq (
        .clk(clk), .rst_n(rst_n),
        .put(alloc_accepted && alloc_may_load), .put_tag(alloc_tag),
        .put_fence(alloc_side_effect),
        .drop(done_valid), .drop_tag(done_tag),
        .ask_tag(query_tag),
        .room(lq_room), .full(lq_full),
        .ask_hit(lq_hit), .ask_older(lq_older), .ask_older_fence(lq_older_fence)
    );

    mo_bank #(.TAG_W(TAG_W), .SLOTS(SQ_SLOTS), .LIMIT(SQ_LIMIT)) u_sq (
        .clk(clk), .rst_n(rst_n),
        .put(alloc_accepted && alloc_may_store), .put_tag(alloc_tag),
        .put_fence(alloc_side_effect),
        .drop(done_valid), .drop_tag(done_tag),
        .ask_tag(query_tag),
        .room(sq_room), .full(sq_full),
        .ask_hit(sq_hit), .ask_older(sq_older), .ask_older_fence(sq_older_fence)
    );

    // readiness: store rules take precedence for entries in both banks
    always_comb begin
        if (sq_hit)
            query_ready = !sq_older && !lq_older && !sq_older_fence;
        else if (lq_hit)
            query_ready = !sq_older && !lq_older_fence;
        else
            query_ready = 1'b0;
    end
endmodule

// File: rtl/mo_checker.sv
module mo_checker #(
    parameter int TAG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_may_load,
    input logic             alloc_may_store,
    input logic             alloc_accepted,
    input logic [TAG_W-1:0] query_tag,
    input logic             query_ready,
    input logic             done_valid,
    input logic [TAG_W-1:0] done_tag,
    input logic             lq_full,
    input logic             sq_full
);
    AST_NO_EMPTY_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_accepted |-> (alloc_may_load || alloc_may_store)); // R1

    AST_FULL_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_full && alloc_may_load) |-> !alloc_accepted); // R2

    AST_FULL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_valid && !done_valid) |=> ($stable(lq_full) && $stable(sq_full))); // R8

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !alloc_valid) |=> !(query_ready && query_tag == $past(done_tag))); // R9
endmodule

bind mem_order_queue mo_checker #(.TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_may_load(alloc_may_load),
    .alloc_may_store(alloc_may_store), .alloc_accepted(alloc_accepted),
    .query_tag(query_tag), .query_ready(query_ready),
    .done_valid(done_valid), .done_tag(done_tag),
    .lq_full(lq_full), .sq_full(sq_full)
);

// File: tb/sim_mem_order_queue.sv
module sim_mem_order_queue;
    localparam int TW = 6;
    localparam int LCAP = 3;
    localparam int SCAP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 0, alloc_may_load = 0, alloc_may_store = 0, alloc_side_effect = 0;
    logic [TW-1:0] alloc_tag = '0, query_tag = '0, done_tag = '0;
    logic done_valid = 0;
    logic alloc_accepted, query_ready, lq_full, sq_full;

    int checks = 0;
    int failures = 0;
    bit m_ld [16];
    bit m_st [16];
    bit m_lf [16];

    always #2 clk = ~clk;

    mem_order_queue #(.TAG_W(TW), .LQ_SLOTS(4), .SQ_SLOTS(4), .LQ_LIMIT(LCAP), .SQ_LIMIT(0)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag),
        .alloc_may_load(alloc_may_load), .alloc_may_store(alloc_may_store),
        .alloc_side_effect(alloc_side_effect), .alloc_accepted(alloc_accepted),
        .query_tag(query_tag), .query_ready(query_ready),
        .done_valid(done_valid), .done_tag(done_tag),
        .lq_full(lq_full), .sq_full(sq_full)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b time=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int lcount();
        int n = 0;
        for (int i = 0; i < 16; i++) n += m_ld[i];
        return n;
    endfunction

    function automatic int scount();
        int n = 0;
        for (int i = 0; i < 16; i++) n += m_st[i];
        return n;
    endfunction

    // age rules: R4 R5 R10 for stores, R6 R7 for loads, R9 absent tag
    function automatic bit exp_ready(input int t);
        if (m_st[t]) begin
            for (int o = 0; o < t; o++) if (m_ld[o] || m_st[o]) return 1'b0;
            return 1'b1;
        end else if (m_ld[t]) begin
            for (int o = 0; o < t; o++) if (m_st[o] || m_lf[o]) return 1'b0;
            return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) begin m_ld[i] = 0; m_st[i] = 0; m_lf[i] = 0; end
    endtask

    task automatic do_alloc(input int t, input logic l, input logic s, input logic se);
        bit exp;
        @(negedge clk);
        alloc_valid = 1; alloc_tag = TW'(t);
        alloc_may_load = l; alloc_may_store = s; alloc_side_effect = se;
        #1;
        exp = (l || s) && (!l || lcount() < LCAP) && (!s || scount() < SCAP);
        check((!l && !s) ? "R1" : "R2", alloc_accepted, exp);
        if (exp) begin
            if (l) begin m_ld[t] = 1; m_lf[t] = se; end
            if (s) m_st[t] = 1;
        end
        @(posedge clk);
        #1 alloc_valid = 0;
    endtask

    task automatic do_done(input int t);
        @(negedge clk);
        done_valid = 1; done_tag = TW'(t);
        @(posedge clk);
        #1 done_valid = 0;
        m_ld[t] = 0; m_st[t] = 0; m_lf[t] = 0;
    endtask

    task automatic check_all(input string req);
        for (int t = 0; t < 8; t++) begin
            query_tag = TW'(t);
            #1;
            check(req, query_ready, exp_ready(t));
        end
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // reset state
        do_reset();
        #1;
        check("R8", lq_full, 1'b0);
        check("R8", sq_full, 1'b0);
        query_tag = '0; #1;
        check("R9", query_ready, 1'b0);

        // R1: no flags, nothing queued
        do_alloc(2, 0, 0, 1);
        check_all("R1");

        // sweep over 3-operation flag mixes: R3 R4 R5 R6 R7 R9 R10
        for (int c = 0; c < 512; c++) begin
            int f [3];
            f[0] = c % 8; f[1] = (c / 8) % 8; f[2] = c / 64;
            do_reset();
            for (int k = 0; k < 3; k++)
                do_alloc(k + 1, f[k][0], f[k][1], f[k][2]);
            check_all("R4_R5_R6_R7_R10");
            for (int k = 0; k < 3; k++) begin
                do_done((c % 2 == 1) ? 3 - k : k + 1);
                check_all("R3_R9");
            end
        end

        // load limit and full flag (R8, R2)
        do_reset();
        do_alloc(1, 1, 0, 0);
        do_alloc(2, 1, 0, 0);
        #1 check("R8", lq_full, 1'b0);
        do_alloc(3, 1, 0, 0);
        #1 check("R8", lq_full, 1'b1);
        do_alloc(4, 1, 0, 0);
        do_alloc(5, 1, 1, 0);
        do_done(1);
        #1 check("R8", lq_full, 1'b0);
        // store bank with zero limit: never full, bounded by slots (R8, R2)
        do_alloc(8, 0, 1, 0);
        do_alloc(9, 0, 1, 0);
        do_alloc(10, 0, 1, 0);
        do_alloc(11, 0, 1, 0);
        #1 check("R8", sq_full, 1'b0);
        do_alloc(12, 0, 1, 0);
        do_alloc(6, 1, 1, 0);
        check_all("R9");
        #1 check("R8", sq_full, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule